// File: doc/BRIEF.md
# FIFO occupancy flow-control monitor

This block sits beside a buffer and watches how full it is. Each cycle it takes the buffer's current occupancy and its full flag. From these it derives two flow-control indications for the sender. The first is busy, an early warning. The second is xoff, a request to stop. Each compares the occupancy against its own programmable threshold, and each has its own enable bit. A force control drives busy active whatever the occupancy is.

Alongside the live indications, the block keeps statistics for software. These are a peak-occupancy watermark, a sticky record that the buffer reached full, and two saturating counters. The counters record how often the occupancy climbed above each threshold. The register bus reaches the block only as write strobes with write data and as plain read-data outputs. The clear controls are write-one pulses.

Top module: `fifo_flow_monitor`

## Requirements
- R1: After the asynchronous active-low reset, busy_o and xoff_o are 0. occ_o, status_o, busy_cnt_o and xoff_cnt_o are all 0. ctrl_o is 0. Both thresholds hold their all-ones value, so thr_o reads 0xFFFFFFFF.
- R2: A write strobe on thr_wr_i loads both thresholds at the next clock edge. The busy threshold comes from bits 15:0 and the xoff threshold from bits 31:16. thr_o reads them back in the same layout.
- R3: The occupancy is strictly compared against each threshold, and the results are registered. status_o bit 1 is high when the occupancy sampled at the last edge exceeded the busy threshold. Bit 2 does the same for the xoff threshold. An occupancy equal to a threshold does not count as above it.
- R4: The control word, written through ctrl_wr_i, has busy enable in bit 0, xoff enable in bit 1 and force-busy in bit 2. busy_o is high when force-busy is set, or when busy enable is set and status bit 1 is high.
- R5: xoff_o is high only when xoff enable is set and status bit 2 is high. Force-busy has no effect on it.
- R6: Each exceedance counter adds one at the edge where its above condition goes from false to true. The counter does not change while the condition stays true, and it counts whatever the enable bits are.
- R7: The exceedance counters saturate at 2^CNT_W-1 and do not wrap.
- R8: A write on clr_wr_i acts as a write-one pulse. Bit 2 zeroes the busy counter and bit 3 zeroes the xoff counter at that edge. A clear wins over a rising edge in the same cycle. Zero bits in the word, or a write of all zeros, change nothing.
- R9: occ_o carries the occupancy sampled at the last edge in bits 15:0 and the watermark in bits 31:16. The watermark is the largest occupancy sampled since reset or since the last watermark clear.
- R10: A clear word with bit 0 set zeroes the watermark at that edge. At the following edge the watermark reloads with the current occupancy.
- R11: status_o bit 0 is set at the edge after full_i is seen high. It stays set until a clear word with bit 1 set. If full_i is high in the same cycle as that clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | 16 | Current buffer occupancy |
| full_i | input | 1 | Buffer full flag |
| thr_wr_i | input | 1 | Threshold word write strobe |
| thr_wdata_i | input | 32 | Threshold write data, xoff high half, busy low half |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 3 | Control write data: force, xoff enable, busy enable |
| clr_wr_i | input | 1 | Clear pulse strobe |
| clr_wdata_i | input | 4 | Clear bits: xoff count, busy count, full, watermark |
| busy_o | output | 1 | Busy flow-control indication |
| xoff_o | output | 1 | Xoff flow-control indication |
| thr_o | output | 32 | Threshold readback |
| ctrl_o | output | 3 | Control readback |
| occ_o | output | 32 | Watermark high half, occupancy low half |
| status_o | output | 3 | Above-xoff, above-busy, sticky full |
| busy_cnt_o | output | 16 | Busy threshold exceedance count |
| xoff_cnt_o | output | 16 | Xoff threshold exceedance count |

## Verification
Some properties are checked on every cycle. The counters hold still while their condition stays true, stay pinned once saturated, and return to zero after a clear. The watermark never falls below the last sampled occupancy unless it is being cleared. The full record stays set until it is cleared, and force-busy always shows on busy_o. Only the bench scenarios can show the rest. These are the strict compare at equality, the gating of each output by its enable, the exact count after a series of crossings, the one-cycle watermark reload after a clear, the priority when set and clear collide, and that an all-zero clear write leaves everything untouched.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  // clear word bit positions (write-one pulses)
  localparam int CLR_PEAK    = 0;
  localparam int CLR_FULL    = 1;
  localparam int CLR_BUSYCNT = 2;
  localparam int CLR_XOFFCNT = 3;
  localparam int CLR_W       = 4;

  // control word bit positions
  localparam int CTL_BUSY_EN = 0;
  localparam int CTL_XOFF_EN = 1;
  localparam int CTL_FORCE   = 2;
  localparam int CTL_W       = 3;

  // number of threshold channels and their indices
  localparam int NUM_CH  = 2;
  localparam int CH_BUSY = 0;
  localparam int CH_XOFF = 1;

  typedef struct packed {
    logic force_busy;
    logic xoff_en;
    logic busy_en;
  } fmon_ctrl_t;
endpackage

// File: rtl/fmon_cfg_regs.sv
module fmon_cfg_regs
  import fmon_pkg::*;
#(
  parameter int LVL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 thr_wr_i,
  input  logic [2*LVL_W-1:0]   thr_wdata_i,
  input  logic                 ctrl_wr_i,
  input  logic [CTL_W-1:0]     ctrl_wdata_i,
  output logic [LVL_W-1:0]     thr_o [NUM_CH],
  output fmon_ctrl_t           ctrl_o
);
  logic [LVL_W-1:0] thr_q [NUM_CH];
  logic [LVL_W-1:0] thr_d [NUM_CH];
  fmon_ctrl_t       ctrl_q, ctrl_d;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_thr
      always_comb begin
        thr_d[g] = thr_q[g];
        if (thr_wr_i) thr_d[g] = thr_wdata_i[g*LVL_W +: LVL_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        thr_q[g] <= '1;
        else if (thr_wr_i) thr_q[g] <= thr_d[g];
      end

      assign thr_o[g] = thr_q[g];
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr_i) ctrl_d = fmon_ctrl_t'(ctrl_wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr_i |=> $stable(thr_q[0]) && $stable(thr_q[1])); // R2
endmodule

// File: rtl/fmon_limit_ch.sv
module fmon_limit_ch #(
  parameter int LVL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic             cnt_clr_i,
  output logic             above_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             above_q, above_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise, sat, cnt_en;

  always_comb begin
    above_d = (level_i > thr_i);
    rise    = above_d && !above_q;
    sat     = (cnt_q == CNT_MAX);
    cnt_en  = cnt_clr_i || (rise && !sat);
    cnt_d   = cnt_q;
    if (cnt_clr_i)          cnt_d = '0;
    else if (rise && !sat)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign above_o = above_q;
  assign cnt_o   = cnt_q;

  AST_CNT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (above_q && !cnt_clr_i) |=> $stable(cnt_q)); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !cnt_clr_i) |=> (cnt_q == CNT_MAX)); // R7
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/fmon_peak_track.sv
module fmon_peak_track #(
  parameter int LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             clr_i,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] peak_o
);
  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] peak_q, peak_d;
  logic             peak_en;

  always_comb begin
    peak_en = clr_i || (level_i > peak_q);
    peak_d  = clr_i ? '0 : level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_d;
  end

  assign level_o = level_q;
  assign peak_o  = peak_q;

  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (peak_q >= $past(level_i))); // R9
  AST_PEAK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (peak_q == '0)); // R10
endmodule

// File: rtl/fifo_flow_monitor.sv
module fifo_flow_monitor
  import fmon_pkg::*;
#(
  parameter int LVL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   level_i,
  input  logic               full_i,
  input  logic               thr_wr_i,
  input  logic [2*LVL_W-1:0] thr_wdata_i,
  input  logic               ctrl_wr_i,
  input  logic [CTL_W-1:0]   ctrl_wdata_i,
  input  logic               clr_wr_i,
  input  logic [CLR_W-1:0]   clr_wdata_i,
  output logic               busy_o,
  output logic               xoff_o,
  output logic [2*LVL_W-1:0] thr_o,
  output logic [CTL_W-1:0]   ctrl_o,
  output logic [2*LVL_W-1:0] occ_o,
  output logic [2:0]         status_o,
  output logic [CNT_W-1:0]   busy_cnt_o,
  output logic [CNT_W-1:0]   xoff_cnt_o
);
  logic [LVL_W-1:0] thr   [NUM_CH];
  logic [CNT_W-1:0] cnt   [NUM_CH];
  logic             above [NUM_CH];
  logic             cnt_clr [NUM_CH];
  fmon_ctrl_t       ctrl;
  logic [CLR_W-1:0] clr_pulse;
  logic [LVL_W-1:0] level_q, peak_q;
  logic             full_q, full_d, full_en;

  assign clr_pulse = clr_wdata_i & {CLR_W{clr_wr_i}};
  assign cnt_clr[CH_BUSY] = clr_pulse[CLR_BUSYCNT];
  assign cnt_clr[CH_XOFF] = clr_pulse[CLR_XOFFCNT];

  fmon_cfg_regs #(.LVL_W(LVL_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_wr_i     (thr_wr_i),
    .thr_wdata_i  (thr_wdata_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .thr_o        (thr),
    .ctrl_o       (ctrl)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      fmon_limit_ch #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (level_i),
        .thr_i     (thr[g]),
        .cnt_clr_i (cnt_clr[g]),
        .above_o   (above[g]),
        .cnt_o     (cnt[g])
      );
      assign thr_o[g*LVL_W +: LVL_W] = thr[g];
    end
  endgenerate

  fmon_peak_track #(.LVL_W(LVL_W)) u_peak (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level_i),
    .clr_i   (clr_pulse[CLR_PEAK]),
    .level_o (level_q),
    .peak_o  (peak_q)
  );

  // sticky full record: set has priority over clear
  always_comb begin
    full_en = full_i || clr_pulse[CLR_FULL];
    full_d  = full_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (full_en) full_q <= full_d;
  end

  assign busy_o     = ctrl.force_busy || (ctrl.busy_en && above[CH_BUSY]);
  assign xoff_o     = ctrl.xoff_en && above[CH_XOFF];
  assign ctrl_o     = ctrl;
  assign occ_o      = {peak_q, level_q};
  assign status_o   = {above[CH_XOFF], above[CH_BUSY], full_q};
  assign busy_cnt_o = cnt[CH_BUSY];
  assign xoff_cnt_o = cnt[CH_XOFF];

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr_pulse[CLR_FULL]) |=> full_q); // R11
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |=> status_o[0]); // R11
  AST_FORCE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.force_busy |-> busy_o); // R4
  AST_XOFF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_o |-> (status_o[2] && ctrl_o[CTL_XOFF_EN])); // R5
endmodule

// File: tb/sim_fifo_flow_monitor.sv
module sim_fifo_flow_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] level_i = '0;
  logic        full_i = 1'b0;
  logic        thr_wr_i = 1'b0;
  logic [31:0] thr_wdata_i = '0;
  logic        ctrl_wr_i = 1'b0;
  logic [2:0]  ctrl_wdata_i = '0;
  logic        clr_wr_i = 1'b0;
  logic [3:0]  clr_wdata_i = '0;
  logic        busy_o, xoff_o;
  logic [31:0] thr_o, occ_o;
  logic [2:0]  ctrl_o, status_o;
  logic [3:0]  busy_cnt_o, xoff_cnt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fifo_flow_monitor #(.LVL_W(16), .CNT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .full_i(full_i),
    .thr_wr_i(thr_wr_i), .thr_wdata_i(thr_wdata_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
    .busy_o(busy_o), .xoff_o(xoff_o), .thr_o(thr_o), .ctrl_o(ctrl_o),
    .occ_o(occ_o), .status_o(status_o),
    .busy_cnt_o(busy_cnt_o), .xoff_cnt_o(xoff_cnt_o)
  );

  // {level, expected busy_o, expected xoff_o}; busy thr 100, xoff thr 200
  localparam logic [17:0] VEC [0:7] = '{
    {16'd50,  1'b0, 1'b0},
    {16'd100, 1'b0, 1'b0},
    {16'd101, 1'b1, 1'b0},
    {16'd200, 1'b1, 1'b0},
    {16'd201, 1'b1, 1'b1},
    {16'd150, 1'b1, 1'b0},
    {16'd99,  1'b0, 1'b0},
    {16'd300, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_pulse(input logic [3:0] bits);
    clr_wr_i = 1'b1; clr_wdata_i = bits;
    tick();
    clr_wr_i = 1'b0; clr_wdata_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bcnt, xcnt, peak;
    logic pb, px;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 xoff", {31'd0, xoff_o}, 32'd0);
    chk("R1 thr", thr_o, 32'hFFFF_FFFF);
    chk("R1 occ", occ_o, 32'd0);
    chk("R1 status", {29'd0, status_o}, 32'd0);
    chk("R1 counts", {24'd0, busy_cnt_o, xoff_cnt_o}, 32'd0);
    chk("R1 ctrl", {29'd0, ctrl_o}, 32'd0);
    rst_n = 1'b1;
    tick();

    thr_wr_i = 1'b1; thr_wdata_i = {16'd200, 16'd100};
    tick();
    thr_wr_i = 1'b0;
    chk("R2 thr readback", thr_o, {16'd200, 16'd100});
    ctrl_wr_i = 1'b1; ctrl_wdata_i = 3'b011;
    tick();
    ctrl_wr_i = 1'b0;

    bcnt = 0; xcnt = 0; peak = 0; pb = 1'b0; px = 1'b0;
    for (int i = 0; i < 8; i++) begin
      level_i = VEC[i][17:2];
      tick();
      if (VEC[i][1] && !pb) bcnt++;
      if (VEC[i][0] && !px) xcnt++;
      pb = VEC[i][1]; px = VEC[i][0];
      if (int'(VEC[i][17:2]) > peak) peak = int'(VEC[i][17:2]);
      chk("R4 busy vector", {31'd0, busy_o}, {31'd0, VEC[i][1]});
      chk("R5 xoff vector", {31'd0, xoff_o}, {31'd0, VEC[i][0]});
      chk("R3 status vector", {29'd0, status_o}, {29'd0, VEC[i][0], VEC[i][1], 1'b0});
    end
    chk("R6 busy count", {28'd0, busy_cnt_o}, bcnt);
    chk("R6 xoff count", {28'd0, xoff_cnt_o}, xcnt);
    chk("R9 occ word", occ_o, {peak[15:0], 16'd300});
    repeat (3) tick();
    chk("R6 count held", {24'd0, busy_cnt_o, xoff_cnt_o}, {24'd0, 4'd2, 4'd2});

    ctrl_wr_i = 1'b1; ctrl_wdata_i = 3'b000;
    tick();
    chk("R4 busy disabled", {31'd0, busy_o}, 32'd0);
    chk("R5 xoff disabled", {31'd0, xoff_o}, 32'd0);
    chk("R3 status ungated", {29'd0, status_o}, 32'd6);
    ctrl_wdata_i = 3'b100;
    tick();
    ctrl_wr_i = 1'b0;
    chk("R4 force busy", {31'd0, busy_o}, 32'd1);
    chk("R5 force no xoff", {31'd0, xoff_o}, 32'd0);
    level_i = 16'd20;
    tick();
    chk("R4 force at low level", {31'd0, busy_o}, 32'd1);

    clr_pulse(4'b0001);
    chk("R10 peak zeroed", occ_o, {16'd0, 16'd20});
    tick();
    chk("R10 peak reload", occ_o, {16'd20, 16'd20});
    level_i = 16'd40; tick();
    chk("R9 peak rises", occ_o, {16'd40, 16'd40});
    level_i = 16'd30; tick();
    chk("R9 peak holds", occ_o, {16'd40, 16'd30});

    clr_pulse(4'b0000);
    chk("R8 zero write counts", {24'd0, busy_cnt_o, xoff_cnt_o}, {24'd0, 4'd2, 4'd2});
    chk("R8 zero write occ", occ_o, {16'd40, 16'd30});

    full_i = 1'b1; tick();
    chk("R11 full set", {29'd0, status_o}, 32'd1);
    full_i = 1'b0; tick(); tick();
    chk("R11 full sticky", {29'd0, status_o}, 32'd1);
    clr_pulse(4'b0010);
    chk("R11 full cleared", {29'd0, status_o}, 32'd0);
    full_i = 1'b1;
    clr_pulse(4'b0010);
    full_i = 1'b0;
    chk("R11 set beats clear", {29'd0, status_o}, 32'd1);
    clr_pulse(4'b0010);
    chk("R11 cleared again", {29'd0, status_o}, 32'd0);

    clr_pulse(4'b0100);
    chk("R8 busy count cleared", {28'd0, busy_cnt_o}, 32'd0);
    chk("R8 xoff count kept", {28'd0, xoff_cnt_o}, 32'd2);

    for (int k = 0; k < 20; k++) begin
      level_i = 16'd300; tick();
      level_i = 16'd20;  tick();
    end
    chk("R7 busy saturates", {28'd0, busy_cnt_o}, 32'd15);
    chk("R7 xoff saturates", {28'd0, xoff_cnt_o}, 32'd15);

    level_i = 16'd300;
    clr_pulse(4'b0100);
    chk("R8 clear beats rise", {28'd0, busy_cnt_o}, 32'd0);
    chk("R8 other count kept", {28'd0, xoff_cnt_o}, 32'd15);
    clr_pulse(4'b1000);
    chk("R8 xoff count cleared", {28'd0, xoff_cnt_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule